// File: doc/BRIEF.md
# DMA Queue Run-State Controller

This block holds the control and status logic of one DMA queue. Software writes a control word that enables the queue, pauses it, selects what happens when a descriptor fails and selects whether the rings sit on the local or the remote side. A separate write starts a queue reset. The block tracks the queue in an eight-state machine and returns its code through a status word. It drives three controls to the copy engine: go, hold and flush. It takes pending, busy, done and error indications back from the engine. It also owns the submission tail and completion head pointers, and a queue reset clears both.

Register offsets that software decodes are 0x0C (submission tail), 0x1C (completion head), 0x20 (control word), 0x24 (reset word) and 0x30 (status word). Reads are combinational on `reg_addr`. Writes take effect at the clock edge on which `reg_wr` is high.

Top module: `dmaq_ctrl`

## Requirements
- R1: After synchronous active-low reset the state code is IDLE (0), the control word, reset word and both pointers read 0, and eng_go, eng_hold, eng_flush and ring_remote are low.
- R2: The control word at 0x20 keeps enable at bit 0, abort-on-error at bit 2, pause at bit 4 and ring side at bit 24, and reads 0 in every other bit. The status word at 0x30 returns the state in bits 3:0 with the codes IDLE=0, RUN=1, CPL=2, PAUSE=3, HALT=4, ABORT=5, WAIT=6, BUFFCLR=7.
- R3: From IDLE the queue enters RUN one edge after enable is 1, pause is 0 and eng_pending is 1. eng_go is high only in RUN.
- R4: eng_done in RUN with no error, or with an error while abort-on-error is 0, moves the queue to CPL for one cycle. From CPL it goes to RUN if work is pending and otherwise to IDLE.
- R5: eng_done with eng_err while abort-on-error is 1 moves the queue to ABORT. The queue stays in ABORT with eng_hold high until a queue reset, whatever the control word holds.
- R6: Pause in RUN with no descriptor in flight moves the queue to PAUSE on the next edge. With eng_busy high the queue waits in WAIT, with eng_hold high and eng_go low, until eng_done and then enters PAUSE. Clearing pause returns the queue to IDLE.
- R7: Clearing enable in RUN moves the queue to HALT, going through WAIT if a descriptor is busy. HALT returns to IDLE once enable is 1 and pause is 0.
- R8: Writing 1 to bit 0 of 0x24 makes that bit read 1 from the next cycle. On the edge after that, both pointers read 0 and the queue enters BUFFCLR with eng_flush high for FLUSH_CYC cycles. It then enters IDLE, and the bit reads 0 again. Writing 0 to the bit has no effect.
- R9: The pointers at 0x0C and 0x1C store the low PTR_W bits of a write and read 0 above them. Pointer writes are ignored while a queue reset is in progress.
- R10: Output ring_remote follows bit 24 of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| eng_pending | input | 1 | Engine has descriptors waiting |
| eng_busy | input | 1 | A descriptor is in flight |
| eng_done | input | 1 | One-cycle descriptor completion pulse |
| eng_err | input | 1 | Completing descriptor failed (valid with eng_done) |
| eng_go | output | 1 | Engine may fetch and run descriptors |
| eng_hold | output | 1 | Engine must not fetch new descriptors |
| eng_flush | output | 1 | Engine must drop internal queue state |
| ring_remote | output | 1 | Rings live on the remote side |
| sq_tail | output | PTR_W | Submission tail pointer |
| cq_head | output | PTR_W | Completion head pointer |

## Verification
The bench builds the block with PTR_W set to 6 and FLUSH_CYC set to 3. The narrow pointer makes masking visible: an all-ones write reads back as 0x3F, and a value above bit 5 loses its high bits. The short flush window lets the bench follow every cycle of BUFFCLR, from the reset bit reading 1 through to the return to IDLE, and try a pointer write while the reset is in progress.

// File: rtl/dmaq_pkg.sv
// Package for the DMA queue controller.
// Holds the state codes that software reads back, the register offsets
// and bit positions that software decodes, and the control-word type.
package dmaq_pkg;

    typedef enum logic [3:0] {
        Q_IDLE  = 4'd0,
        Q_RUN   = 4'd1,
        Q_CPL   = 4'd2,
        Q_PAUSE = 4'd3,
        Q_HALT  = 4'd4,
        Q_ABORT = 4'd5,
        Q_WAIT  = 4'd6,
        Q_FLUSH = 4'd7
    } qstate_e;

    localparam int OFS_SQ_TAIL = 'h0C;
    localparam int OFS_CQ_HEAD = 'h1C;
    localparam int OFS_CTRL    = 'h20;
    localparam int OFS_QRST    = 'h24;
    localparam int OFS_STAT    = 'h30;

    localparam int BIT_EN      = 0;
    localparam int BIT_ABORT   = 2;
    localparam int BIT_PAUSE   = 4;
    localparam int BIT_REMOTE  = 24;
    localparam int BIT_QRST    = 0;

    typedef struct packed {
        logic remote;
        logic pause;
        logic abort_en;
        logic en;
    } qctrl_t;

endpackage

// File: rtl/dmaq_regs.sv
// Control register and pointer storage for one DMA queue.
// Assumes one write per cycle. A queue reset request stays pending
// until the state machine reports the end of the flush. Pointers are
// held at zero for as long as the reset is pending.
module dmaq_regs
    import dmaq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flush_done,
    output qctrl_t            ctrl,
    output logic              rst_pend,
    output logic [PTR_W-1:0]  sq_tail,
    output logic [PTR_W-1:0]  cq_head
);

    localparam logic [ADDR_W-1:0] A_SQ   = ADDR_W'(OFS_SQ_TAIL);
    localparam logic [ADDR_W-1:0] A_CQ   = ADDR_W'(OFS_CQ_HEAD);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_QRST = ADDR_W'(OFS_QRST);

    // Control word: capture the four defined fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr && addr == A_CTRL) begin
            ctrl.en       <= wdata[BIT_EN];
            ctrl.abort_en <= wdata[BIT_ABORT];
            ctrl.pause    <= wdata[BIT_PAUSE];
            ctrl.remote   <= wdata[BIT_REMOTE];
        end
    end

    // Reset request: set by a write of 1, cleared when the flush ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pend <= 1'b0;
        end else if (flush_done) begin
            rst_pend <= 1'b0;
        end else if (wr && addr == A_QRST && wdata[BIT_QRST]) begin
            rst_pend <= 1'b1;
        end
    end

    // Ring pointers: writable, forced to zero while a reset is pending.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_pend) begin
            sq_tail <= '0;
            cq_head <= '0;
        end else if (wr) begin
            if (addr == A_SQ) sq_tail <= wdata[PTR_W-1:0];
            if (addr == A_CQ) cq_head <= wdata[PTR_W-1:0];
        end
    end

    assert_ptr_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend |=> (sq_tail == '0 && cq_head == '0));

    assert_ptr_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_SQ && !rst_pend) |=> sq_tail == $past(wdata[PTR_W-1:0]));

    assert_qrst_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_QRST && wdata[BIT_QRST] && !flush_done) |=> rst_pend);

endmodule

// File: rtl/dmaq_fsm.sv
// Run-state machine for one DMA queue.
// Assumes eng_done is a one-cycle pulse and eng_err is valid with it.
// A pending queue reset overrides every state. The flush state lasts
// FLUSH_CYC cycles and then returns to IDLE.
module dmaq_fsm
    import dmaq_pkg::*;
#(
    parameter int FLUSH_CYC = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  qctrl_t  ctrl,
    input  logic    rst_pend,
    input  logic    eng_pending,
    input  logic    eng_busy,
    input  logic    eng_done,
    input  logic    eng_err,
    output qstate_e state,
    output logic    flush_done,
    output logic    eng_go,
    output logic    eng_hold,
    output logic    eng_flush
);

    localparam int CW = $clog2(FLUSH_CYC + 1);

    qstate_e       nxt;
    logic [CW-1:0] cnt;
    logic          bad_end;

    // Flags a failed descriptor under the abort policy, and the flush end.
    always_comb begin
        bad_end    = eng_done && eng_err && ctrl.abort_en;
        flush_done = (state == Q_FLUSH) && (cnt == CW'(FLUSH_CYC - 1));
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        if (rst_pend && state != Q_FLUSH) begin
            nxt = Q_FLUSH;
        end else begin
            case (state)
                Q_IDLE:  if (ctrl.pause) nxt = Q_PAUSE;
                         else if (ctrl.en && eng_pending) nxt = Q_RUN;
                Q_RUN:   if (eng_done) nxt = bad_end ? Q_ABORT : Q_CPL;
                         else if (ctrl.pause || !ctrl.en)
                             nxt = eng_busy ? Q_WAIT : (ctrl.pause ? Q_PAUSE : Q_HALT);
                Q_WAIT:  if (eng_done) begin
                             if (bad_end) nxt = Q_ABORT;
                             else if (ctrl.pause) nxt = Q_PAUSE;
                             else if (!ctrl.en) nxt = Q_HALT;
                             else nxt = Q_CPL;
                         end
                Q_CPL:   if (ctrl.pause) nxt = Q_PAUSE;
                         else if (!ctrl.en) nxt = Q_HALT;
                         else nxt = eng_pending ? Q_RUN : Q_IDLE;
                Q_PAUSE: if (!ctrl.pause) nxt = Q_IDLE;
                Q_HALT:  if (ctrl.en && !ctrl.pause) nxt = Q_IDLE;
                Q_ABORT: nxt = Q_ABORT;
                Q_FLUSH: if (flush_done) nxt = Q_IDLE;
                default: nxt = Q_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= Q_IDLE;
        else        state <= nxt;
    end

    // Flush length counter, zero outside the flush state.
    always_ff @(posedge clk) begin
        if (!rst_n || state != Q_FLUSH) cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    // Engine controls decoded from the state.
    always_comb begin
        eng_go    = (state == Q_RUN);
        eng_hold  = (state == Q_WAIT) || (state == Q_PAUSE) ||
                    (state == Q_HALT) || (state == Q_ABORT);
        eng_flush = (state == Q_FLUSH);
    end

    assert_abort_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_ABORT && !rst_pend) |=> state == Q_ABORT);

    assert_abort_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == Q_RUN || state == Q_WAIT) && eng_done && eng_err &&
         ctrl.abort_en && !rst_pend) |=> state == Q_ABORT);

    assert_pause_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_RUN && ctrl.pause && !eng_busy && !eng_done && !rst_pend)
        |=> state == Q_PAUSE);

    assert_flush_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> state == Q_IDLE);

endmodule

// File: rtl/dmaq_rdmux.sv
// Read-back multiplexer for the queue registers.
// Purely combinational. Unknown offsets and undefined bits read 0.
module dmaq_rdmux
    import dmaq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  qctrl_t            ctrl,
    input  logic              rst_pend,
    input  logic [PTR_W-1:0]  sq_tail,
    input  logic [PTR_W-1:0]  cq_head,
    input  qstate_e           state,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_SQ   = ADDR_W'(OFS_SQ_TAIL);
    localparam logic [ADDR_W-1:0] A_CQ   = ADDR_W'(OFS_CQ_HEAD);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_QRST = ADDR_W'(OFS_QRST);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    // Select and place the addressed fields.
    always_comb begin
        rdata = '0;
        case (addr)
            A_SQ:   rdata[PTR_W-1:0] = sq_tail;
            A_CQ:   rdata[PTR_W-1:0] = cq_head;
            A_CTRL: begin
                rdata[BIT_EN]     = ctrl.en;
                rdata[BIT_ABORT]  = ctrl.abort_en;
                rdata[BIT_PAUSE]  = ctrl.pause;
                rdata[BIT_REMOTE] = ctrl.remote;
            end
            A_QRST: rdata[BIT_QRST] = rst_pend;
            A_STAT: rdata[3:0] = state;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmaq_ctrl.sv
// Top of the DMA queue controller: register storage, run-state machine
// and read-back. Assumes a single clock and a synchronous active-low
// reset. The copy engine is outside this block.
module dmaq_ctrl
    import dmaq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int PTR_W     = 10,
    parameter int FLUSH_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_pending,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_err,
    output logic              eng_go,
    output logic              eng_hold,
    output logic              eng_flush,
    output logic              ring_remote,
    output logic [PTR_W-1:0]  sq_tail,
    output logic [PTR_W-1:0]  cq_head
);

    qctrl_t  ctrl;
    logic    rst_pend;
    logic    flush_done;
    qstate_e state;

    dmaq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .flush_done (flush_done),
        .ctrl       (ctrl),
        .rst_pend   (rst_pend),
        .sq_tail    (sq_tail),
        .cq_head    (cq_head)
    );

    dmaq_fsm #(.FLUSH_CYC(FLUSH_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .rst_pend    (rst_pend),
        .eng_pending (eng_pending),
        .eng_busy    (eng_busy),
        .eng_done    (eng_done),
        .eng_err     (eng_err),
        .state       (state),
        .flush_done  (flush_done),
        .eng_go      (eng_go),
        .eng_hold    (eng_hold),
        .eng_flush   (eng_flush)
    );

    dmaq_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_rdmux (
        .addr     (reg_addr),
        .ctrl     (ctrl),
        .rst_pend (rst_pend),
        .sq_tail  (sq_tail),
        .cq_head  (cq_head),
        .state    (state),
        .rdata    (reg_rdata)
    );

    // Ring side selection straight from the control word.
    always_comb ring_remote = ctrl.remote;

    assert_flush_ptrs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FLUSH) |-> (sq_tail == '0 && cq_head == '0));

    assert_flush_ends_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FLUSH && flush_done) |=> !rst_pend);

endmodule

// File: tb/test_dmaq_ctrl.sv
module test_dmaq_ctrl;

    localparam int PW = 6;
    localparam int FC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          eng_pending = 1'b0, eng_busy = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
    logic          eng_go, eng_hold, eng_flush, ring_remote;
    logic [PW-1:0] sq_tail, cq_head;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dmaq_ctrl #(.ADDR_W(8), .DATA_W(32), .PTR_W(PW), .FLUSH_CYC(FC)) i_dmaq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_pending(eng_pending), .eng_busy(eng_busy), .eng_done(eng_done),
        .eng_err(eng_err), .eng_go(eng_go), .eng_hold(eng_hold),
        .eng_flush(eng_flush), .ring_remote(ring_remote),
        .sq_tail(sq_tail), .cq_head(cq_head)
    );

    // Register table: {offset, write data, expected read-back}, R2 and R9.
    localparam logic [71:0] VEC [7] = '{
        {8'h20, 32'hFFFF_FFFF, 32'h0100_0015},
        {8'h20, 32'h0000_0004, 32'h0000_0004},
        {8'h0C, 32'hFFFF_FFFF, 32'h0000_003F},
        {8'h1C, 32'h0000_0123, 32'h0000_0023},
        {8'h0C, 32'h0000_0005, 32'h0000_0005},
        {8'h20, 32'h0100_0000, 32'h0100_0000},
        {8'h20, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_st(input logic [3:0] exp, input string tag);
        logic [31:0] v;
        rd(8'h30, v);
        chk(v, {28'd0, exp}, tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual hung, expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_st(4'd0, "R1 state");
        rd(8'h20, v); chk(v, 0, "R1 ctrl");
        rd(8'h24, v); chk(v, 0, "R1 qrst");
        rd(8'h0C, v); chk(v, 0, "R1 sq_tail");
        rd(8'h1C, v); chk(v, 0, "R1 cq_head");
        chk({eng_go, eng_hold, eng_flush, ring_remote}, 0, "R1 outputs");

        // R2/R9/R10 register table
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            chk(v, VEC[i][31:0], "R2/R9 table");
            if (i == 5) chk(ring_remote, 1, "R10 remote on");
        end
        chk(ring_remote, 0, "R10 remote off");
        chk_st(4'd0, "R2 idle after table");

        // R3/R4 normal run
        wr(8'h20, 32'h1);
        eng_pending = 1; tick();
        chk_st(4'd1, "R3 run"); chk(eng_go, 1, "R3 go");
        eng_busy = 1; tick();
        eng_done = 1; tick(); eng_done = 0; eng_busy = 0;
        chk_st(4'd2, "R4 cpl"); chk(eng_go, 0, "R3 go low in cpl");
        tick(); chk_st(4'd1, "R4 back to run");
        eng_pending = 0; eng_done = 1; tick(); eng_done = 0;
        chk_st(4'd2, "R4 cpl2");
        tick(); chk_st(4'd0, "R4 idle");

        // R4 error in skip mode
        eng_pending = 1; tick();
        eng_done = 1; eng_err = 1; tick(); eng_done = 0; eng_err = 0;
        chk_st(4'd2, "R4 skip error");
        eng_pending = 0; tick(); chk_st(4'd0, "R4 skip idle");

        // R6 pause with busy descriptor
        eng_pending = 1; tick(); eng_busy = 1;
        wr(8'h20, 32'h11); chk_st(4'd1, "R6 still run");
        tick(); chk_st(4'd6, "R6 wait");
        chk({eng_hold, eng_go}, 2'b10, "R6 hold in wait");
        tick(); chk_st(4'd6, "R6 wait held");
        eng_done = 1; eng_busy = 0; tick(); eng_done = 0;
        chk_st(4'd3, "R6 pause");
        tick(); chk_st(4'd3, "R6 pause held");
        wr(8'h20, 32'h1);
        tick(); chk_st(4'd0, "R6 unpause idle");
        tick(); chk_st(4'd1, "R6 run again");

        // R6 pause with nothing in flight
        wr(8'h20, 32'h11);
        tick(); chk_st(4'd3, "R6 direct pause");
        eng_pending = 0;
        wr(8'h20, 32'h1);
        tick(); chk_st(4'd0, "R6 idle");

        // R7 disable
        eng_pending = 1; tick();
        wr(8'h20, 32'h0);
        tick(); chk_st(4'd4, "R7 halt"); chk(eng_go, 0, "R7 go low");
        tick(); chk_st(4'd4, "R7 halt held");
        wr(8'h20, 32'h1); eng_pending = 0;
        tick(); chk_st(4'd0, "R7 idle");

        // R5 abort mode
        wr(8'h20, 32'h5);
        eng_pending = 1; tick();
        eng_done = 1; eng_err = 1; tick(); eng_done = 0; eng_err = 0;
        chk_st(4'd5, "R5 abort"); chk(eng_hold, 1, "R5 hold");
        wr(8'h20, 32'h0);
        repeat (3) tick();
        chk_st(4'd5, "R5 abort sticky");
        eng_pending = 0;

        // R8 queue reset
        wr(8'h0C, 32'h7); wr(8'h1C, 32'h9);
        wr(8'h24, 32'h0);
        rd(8'h24, v); chk(v, 0, "R8 write 0 ignored");
        chk_st(4'd5, "R8 still abort");
        wr(8'h24, 32'h1);
        rd(8'h24, v); chk(v, 1, "R8 bit set");
        tick();
        chk_st(4'd7, "R8 bufclr"); chk(eng_flush, 1, "R8 flush");
        chk({26'd0, sq_tail}, 0, "R8 sq cleared");
        chk({26'd0, cq_head}, 0, "R8 cq cleared");
        wr(8'h0C, 32'h5);
        chk({26'd0, sq_tail}, 0, "R9 write ignored in reset");
        chk_st(4'd7, "R8 bufclr held");
        tick(); chk_st(4'd7, "R8 bufclr last");
        tick(); chk_st(4'd0, "R8 idle after reset");
        rd(8'h24, v); chk(v, 0, "R8 bit self-cleared");
        chk(eng_flush, 0, "R8 flush off");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule